// File: doc/BRIEF.md
# Maskable Edge/Level Interrupt Collector

This block gathers a parameterised set of internal event lines into per-source status bits and drives one interrupt line toward a host processor. Each source has its own enable bit and a two-bit sensitivity field. The field selects whether the source latches on a rising edge or a falling edge, or whether its status simply follows the line level. Edge-latched bits stay set until the host reads the status with the read-clear strobe asserted.

A global two-bit output mode shapes the final line. The line can be active-high and driven, active-low and driven, or active-low open-drain. In open-drain mode the block only ever pulls the line low and otherwise releases it through its output-enable. This lets several devices share one host interrupt line in a wired-OR arrangement. Masking gates only the output: a disabled source still records its events in the status bits.

Top module: `irq_collector`

## Requirements
- R1: After reset all status bits are 0, all enables are 0, every sensitivity field is 00 and the output mode is 00; the line then reads `irq_pin_o`=1 with `irq_oe_o`=1.
- R2: With sensitivity 00 (rising), a source whose line goes 0 to 1 shows status 1 one clock later, and the bit stays 1 after the line returns to 0.
- R3: With sensitivity 01 (falling), a 1-to-0 transition sets the status bit one clock later; a 0-to-1 transition does not.
- R4: With sensitivity 10 or 11 (level), the status bit equals the source level sampled at the previous clock edge.
- R5: A clock edge with `stat_rd_i`=1 clears every edge-latched status bit that sees no new qualifying edge in that cycle; level bits keep following their source.
- R6: A qualifying edge in the same cycle as the clearing read leaves its status bit set.
- R7: The interrupt is active exactly when some status bit is 1 and its enable bit (`mask_rdata_o` bit = 1) is 1; a disabled source still sets its status bit.
- R8: Output mode 00 (and reserved 11): `irq_oe_o`=1 and `irq_pin_o` is the inverse of the active condition.
- R9: Output mode 01: `irq_oe_o`=1 and `irq_pin_o` equals the active condition.
- R10: Output mode 10 (open-drain): `irq_pin_o` is always 0 and `irq_oe_o` equals the active condition.
- R11: The enable, sensitivity and output-mode read ports return the last written value one clock after the write strobe. Sensitivity field i is bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Internal event lines, one per source |
| mask_we_i | input | 1 | Write strobe for the enable register |
| mask_wdata_i | input | N_SRC | Enable write data, 1 = source may assert the line |
| mask_rdata_o | output | N_SRC | Enable register contents |
| sens_we_i | input | 1 | Write strobe for the sensitivity register |
| sens_wdata_i | input | 2*N_SRC | Sensitivity write data, two bits per source |
| sens_rdata_o | output | 2*N_SRC | Sensitivity register contents |
| omode_we_i | input | 1 | Write strobe for the output mode |
| omode_wdata_i | input | 2 | Output mode write data |
| omode_rdata_o | output | 2 | Output mode contents |
| stat_rd_i | input | 1 | Read-clear strobe for the status bits |
| stat_rdata_o | output | N_SRC | Status bits |
| irq_pin_o | output | 1 | Interrupt line level |
| irq_oe_o | output | 1 | Output enable for the interrupt line |

## Verification
A stepped table drives rising, falling and level sources side by side, with one disabled source. It separates latch-and-hold behaviour from follow-the-level behaviour, and it shows whether masking suppresses the line or the status. The table holds a clear with no pending edge and a clear that coincides with a fresh edge, so a design that drops the coincident edge or clears level bits is caught. Directed steps then walk one latched, disabled event through enabling and all four output modes. Each mode must produce its own pin/enable pair for the same active and inactive condition.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam logic [1:0] SENS_RISE  = 2'b00;
   localparam logic [1:0] SENS_FALL  = 2'b01;
   localparam logic [1:0] SENS_LEVEL = 2'b10;
   localparam logic [1:0] SENS_LVL2  = 2'b11;

   localparam logic [1:0] OM_LOW_DRV  = 2'b00;
   localparam logic [1:0] OM_HIGH_DRV = 2'b01;
   localparam logic [1:0] OM_LOW_OD   = 2'b10;
   localparam logic [1:0] OM_RSVD     = 2'b11;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
   import irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       src_i,
   input  logic [1:0] sens_i,
   input  logic       clr_i,
   output logic       stat_o
);
   logic prev_q;
   logic stat_q;
   logic hit;
   logic is_level;

   assign is_level = sens_i[1];

   always_comb begin
      case (sens_i)
         SENS_RISE: hit = src_i & ~prev_q;
         SENS_FALL: hit = ~src_i & prev_q;
         default:   hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         stat_q <= 1'b0;
      end else begin
         prev_q <= src_i;
         if (is_level) stat_q <= src_i;
         else          stat_q <= (stat_q & ~clr_i) | hit;
      end
   end

   assign stat_o = stat_q;

   // R2: rising edge latches
   a_r2_rise_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (sens_i == SENS_RISE && src_i && !prev_q) |=> stat_q);
   // R3: falling edge latches
   a_r3_fall_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (sens_i == SENS_FALL && !src_i && prev_q) |=> stat_q);
   // R4: level follows source
   a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (sens_i[1]) |=> (stat_q == $past(src_i)));
   // R5: clear without new edge empties the bit
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!sens_i[1] && clr_i && (src_i == prev_q)) |=> !stat_q);
   // R6: edge coinciding with clear survives
   a_r6_clear_race: assert property (@(posedge clk) disable iff (!rst_n)
      (sens_i == SENS_RISE && clr_i && src_i && !prev_q) |=> stat_q);
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
   import irq_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic       act_i,
   output logic       pin_o,
   output logic       oe_o
);
   always_comb begin
      case (mode_i)
         OM_HIGH_DRV: begin pin_o = act_i;  oe_o = 1'b1;  end
         OM_LOW_OD:   begin pin_o = 1'b0;   oe_o = act_i; end
         default:     begin pin_o = ~act_i; oe_o = 1'b1;  end
      endcase
   end
endmodule

// File: rtl/irq_collector.sv
module irq_collector
   import irq_pkg::*;
#(
   parameter int N_SRC = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_SRC-1:0]     src_i,
   input  logic                 mask_we_i,
   input  logic [N_SRC-1:0]     mask_wdata_i,
   output logic [N_SRC-1:0]     mask_rdata_o,
   input  logic                 sens_we_i,
   input  logic [2*N_SRC-1:0]   sens_wdata_i,
   output logic [2*N_SRC-1:0]   sens_rdata_o,
   input  logic                 omode_we_i,
   input  logic [1:0]           omode_wdata_i,
   output logic [1:0]           omode_rdata_o,
   input  logic                 stat_rd_i,
   output logic [N_SRC-1:0]     stat_rdata_o,
   output logic                 irq_pin_o,
   output logic                 irq_oe_o
);
   localparam int SENS_W = 2 * N_SRC;

   generate
      if (N_SRC < 1 || N_SRC > 64) begin : g_bad_width
         $error("irq_collector: N_SRC must be 1..64");
      end
   endgenerate

   logic [N_SRC-1:0]  mask_q;
   logic [SENS_W-1:0] sens_q;
   logic [1:0]        omode_q;
   logic [N_SRC-1:0]  stat;
   logic              act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         sens_q  <= '0;
         omode_q <= OM_LOW_DRV;
      end else begin
         if (mask_we_i)  mask_q  <= mask_wdata_i;
         if (sens_we_i)  sens_q  <= sens_wdata_i;
         if (omode_we_i) omode_q <= omode_wdata_i;
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      irq_src_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .src_i  (src_i[i]),
         .sens_i (sens_q[2*i +: 2]),
         .clr_i  (stat_rd_i),
         .stat_o (stat[i])
      );
   end

   assign act = |(stat & mask_q);

   irq_pin_drv u_drv (
      .mode_i (omode_q),
      .act_i  (act),
      .pin_o  (irq_pin_o),
      .oe_o   (irq_oe_o)
   );

   assign mask_rdata_o  = mask_q;
   assign sens_rdata_o  = sens_q;
   assign omode_rdata_o = omode_q;
   assign stat_rdata_o  = stat;

   // R7: with every enable off the line is inactive in every mode
   a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> ((omode_q == OM_HIGH_DRV) ? !irq_pin_o :
                          (omode_q == OM_LOW_OD)   ? !irq_oe_o : irq_pin_o));
   // R10: open-drain never drives high
   a_r10_od_low: assert property (@(posedge clk) disable iff (!rst_n)
      (omode_q == OM_LOW_OD) |-> !irq_pin_o);
   // R8: driven modes always enable the output
   a_r8_driven_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (omode_q != OM_LOW_OD) |-> irq_oe_o);
   // R11: a written enable value appears one clock later
   a_r11_mask_wr: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_i |=> (mask_rdata_o == $past(mask_wdata_i)));
endmodule

// File: tb/sim_irq_collector.sv
`timescale 1ns/1ps
module sim_irq_collector;
   localparam int N = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   src = '0;
   logic           mask_we = 1'b0;
   logic [N-1:0]   mask_wd = '0;
   logic [N-1:0]   mask_rd;
   logic           sens_we = 1'b0;
   logic [2*N-1:0] sens_wd = '0;
   logic [2*N-1:0] sens_rd;
   logic           om_we = 1'b0;
   logic [1:0]     om_wd = '0;
   logic [1:0]     om_rd;
   logic           rd = 1'b0;
   logic [N-1:0]   stat;
   logic           pin, oe;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_collector #(.N_SRC(N)) u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src),
      .mask_we_i(mask_we), .mask_wdata_i(mask_wd), .mask_rdata_o(mask_rd),
      .sens_we_i(sens_we), .sens_wdata_i(sens_wd), .sens_rdata_o(sens_rd),
      .omode_we_i(om_we), .omode_wdata_i(om_wd), .omode_rdata_o(om_rd),
      .stat_rd_i(rd), .stat_rdata_o(stat), .irq_pin_o(pin), .irq_oe_o(oe));

   // step: {src, read-clear, expected status, expected pin (mode 00)}
   typedef struct packed {
      logic [7:0] s;
      logic       r;
      logic [7:0] es;
      logic       ep;
   } step_t;

   localparam int NSTEP = 12;
   localparam step_t TBL [NSTEP] = '{
      '{8'h00, 1'b0, 8'h00, 1'b1},  // R1 idle
      '{8'h01, 1'b0, 8'h01, 1'b0},  // R2 rise latches
      '{8'h00, 1'b0, 8'h01, 1'b0},  // R2 held after line drops
      '{8'h00, 1'b1, 8'h00, 1'b1},  // R5 clear
      '{8'h02, 1'b0, 8'h00, 1'b1},  // R3 rising ignored on falling source
      '{8'h00, 1'b0, 8'h02, 1'b0},  // R3 fall latches
      '{8'h04, 1'b1, 8'h04, 1'b0},  // R4 level 10, R5 clears edge bit
      '{8'h0C, 1'b1, 8'h0C, 1'b0},  // R4 level 11, R5 level untouched
      '{8'h00, 1'b0, 8'h00, 1'b1},  // R4 level drops
      '{8'h80, 1'b0, 8'h80, 1'b1},  // R7 disabled source latches, line quiet
      '{8'h81, 1'b1, 8'h01, 1'b0},  // R6 edge with clear survives
      '{8'h00, 1'b1, 8'h00, 1'b1}   // R5 final clear
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 stat", stat, 0);
      chk("R1 mask", mask_rd, 0);
      chk("R1 sens", sens_rd, 0);
      chk("R1 omode", om_rd, 0);
      chk("R1 pin", pin, 1);
      chk("R1 oe", oe, 1);
      rst_n = 1'b1;
      tick();

      // R11 configuration: bit0 rise, bit1 fall, bit2 level 10, bit3 level 11, rest rise
      sens_we = 1'b1; sens_wd = 16'h00E4;
      mask_we = 1'b1; mask_wd = 8'h7F;
      tick();
      sens_we = 1'b0; mask_we = 1'b0;
      chk("R11 sens readback", sens_rd, 16'h00E4);
      chk("R11 mask readback", mask_rd, 8'h7F);

      for (int i = 0; i < NSTEP; i++) begin
         src = TBL[i].s; rd = TBL[i].r;
         tick();
         chk($sformatf("R2-7 step %0d stat", i), stat, TBL[i].es);
         chk($sformatf("R8 step %0d pin", i), pin, TBL[i].ep);
      end
      rd = 1'b0;

      // disabled bit7 latched, line quiet
      src = 8'h80; tick();
      chk("R7 masked latch", stat, 8'h80);
      chk("R7 masked pin", pin, 1);
      mask_we = 1'b1; mask_wd = 8'hFF; tick(); mask_we = 1'b0;
      chk("R7 enabled pin", pin, 0);
      chk("R8 oe", oe, 1);
      om_we = 1'b1; om_wd = 2'b01; tick(); om_we = 1'b0;
      chk("R11 omode readback", om_rd, 2'b01);
      chk("R9 pin active", pin, 1);
      chk("R9 oe", oe, 1);
      om_we = 1'b1; om_wd = 2'b10; tick(); om_we = 1'b0;
      chk("R10 pin active", pin, 0);
      chk("R10 oe active", oe, 1);
      rd = 1'b1; tick(); rd = 1'b0;
      chk("R5 cleared", stat, 0);
      chk("R10 pin idle", pin, 0);
      chk("R10 oe idle", oe, 0);
      om_we = 1'b1; om_wd = 2'b11; tick(); om_we = 1'b0;
      chk("R8 reserved pin idle", pin, 1);
      chk("R8 reserved oe", oe, 1);
      om_we = 1'b1; om_wd = 2'b01; tick(); om_we = 1'b0;
      chk("R9 pin idle", pin, 0);

      // R3 falling bit with mode 01: fall sets line high
      src = 8'h82; tick();
      src = 8'h80; tick();
      chk("R3 fall stat", stat, 8'h02);
      chk("R9 fall pin", pin, 1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule